// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits between the execute stage of a 32-bit little-endian integer data path and the data memory port. It arranges bytes into the correct lanes for loads and stores. On the store side it receives a store kind, the effective address and the source register value. From these it forms a word-aligned memory address, a per-byte write strobe and write data with each byte placed in its lane. The store kinds are byte, halfword, word, and the two partial-word kinds, store-left and store-right.

On the load side it receives a load kind, the same effective address, the raw memory word and the current value of the destination register. It forms the value to write back to the register. The load kinds are signed and unsigned byte, signed and unsigned halfword, word, load-left and load-right. The two partial-word loads merge bytes from memory into the old register value.

The two low address bits are decoded once into a one-hot lane mask, and both sides select their bytes with that mask. All outputs are registered, so they appear one clock after the inputs, and a synchronous active-high reset clears them.

Top module: `lsu_lane_align`

## Requirements
- R1: While `rst` is high at a rising edge, every output is zero after that edge. Otherwise every output reflects the inputs that were present at the previous rising edge (one cycle of latency).
- R2: `mem_addr` equals `eff_addr` with bits 1:0 cleared.
- R3: Store kind codes are 0 idle, 1 byte, 2 halfword, 3 word, 4 store-left and 5 store-right. Codes 0, 6 and 7 give `wr_strb` = 0000 and `wr_data` = 0.
- R4: A byte store sets only the strobe bit whose index equals the offset `eff_addr[1:0]`; strobe bit i covers data bits 8i+7:8i. Its data is `st_reg[7:0]` copied into all four lanes.
- R5: A halfword store gives strobe 1100 when `eff_addr[1]` is 1 and 0011 when it is 0. Its data is `st_reg[15:0]` copied into both halves. Only offsets 0 and 2 are defined.
- R6: A word store gives strobe 1111 and data equal to `st_reg`.
- R7: Store-left at offset k sets strobe bits 0 through k. Its data is `st_reg` shifted right by 8*(3-k) bits with zero fill.
- R8: Store-right at offset k sets strobe bits k through 3. Its data is `st_reg` shifted left by 8*k bits with zero fill.
- R9: Load kind codes are 0 idle, 1 signed byte, 2 unsigned byte, 3 signed halfword, 4 unsigned halfword, 5 word, 6 load-left and 7 load-right. A byte load takes memory bits 8k+7:8k at offset k. The signed kind sign-extends it and the unsigned kind zero-extends it.
- R10: A halfword load takes `mem_rdata[31:16]` when `eff_addr[1]` is 1 and `mem_rdata[15:0]` otherwise. The signed kind sign-extends it and the unsigned kind zero-extends it.
- R11: A word load returns `mem_rdata` unchanged. The idle load kind returns zero.
- R12: Load-left at offset k returns the low 8*(k+1) bits of `mem_rdata` in the top of the result, above the low 8*(3-k) bits of `old_reg`.
- R13: Load-right at offset k returns the top 8*k bits of `old_reg` in the top of the result, above `mem_rdata` shifted right by 8*k bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_op | input | 3 | Store kind code |
| ld_op | input | 3 | Load kind code |
| eff_addr | input | 32 | Effective byte address |
| st_reg | input | 32 | Store source register value |
| mem_rdata | input | 32 | Raw word read from memory |
| old_reg | input | 32 | Current destination register value |
| mem_addr | output | 32 | Word-aligned memory address |
| wr_strb | output | 4 | Per-byte write strobe |
| wr_data | output | 32 | Lane-positioned write data |
| ld_result | output | 32 | Register write-back value |

## Verification
The assertions assume that each registered output depends only on the inputs of the previous cycle. They are armed only from the second edge after reset is released. They also assume that halfword kinds never come with an odd offset, because strobe and data are left undefined there. The stimulus respects this: for halfword kinds it clears `eff_addr[0]`, while every other kind gets any offset, including random codes 6 and 7 on the store side.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BYTE  = 3'd1,
    ST_HALF  = 3'd2,
    ST_WORD  = 3'd3,
    ST_LEFT  = 3'd4,
    ST_RIGHT = 3'd5
  } store_kind_e;

  typedef enum logic [2:0] {
    LD_IDLE   = 3'd0,
    LD_BYTE_S = 3'd1,
    LD_BYTE_U = 3'd2,
    LD_HALF_S = 3'd3,
    LD_HALF_U = 3'd4,
    LD_WORD   = 3'd5,
    LD_LEFT   = 3'd6,
    LD_RIGHT  = 3'd7
  } load_kind_e;

endpackage

// File: rtl/lsu_lane_decode.sv
module lsu_lane_decode #(
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0] offset,
  output logic [LANES-1:0] lane_mask
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_mask[i] = (offset == OFF_W'(i));
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int HALVES = LANES / 2
) (
  input  store_kind_e         kind,
  input  logic [LANES-1:0]    lane_mask,
  input  logic [DATA_W-1:0]   src,
  output logic [LANES-1:0]    strb,
  output logic [DATA_W-1:0]   data
);
  logic [LANES-1:0]  left_strb, right_strb, half_strb;
  logic [DATA_W-1:0] left_term  [LANES];
  logic [DATA_W-1:0] right_term [LANES];
  logic [DATA_W-1:0] left_data, right_data;

  for (genvar k = 0; k < LANES; k++) begin : g_off
    localparam int LSH = LANE_W * (LANES - 1 - k);
    localparam int RSH = LANE_W * k;
    assign left_term[k]  = lane_mask[k] ? (src >> LSH) : '0;
    assign right_term[k] = lane_mask[k] ? (src << RSH) : '0;
    assign left_strb[k]  = |lane_mask[LANES-1:k];
    assign right_strb[k] = |lane_mask[k:0];
  end

  for (genvar p = 0; p < HALVES; p++) begin : g_half
    assign half_strb[2*p]   = lane_mask[2*p] | lane_mask[2*p+1];
    assign half_strb[2*p+1] = lane_mask[2*p] | lane_mask[2*p+1];
  end

  always_comb begin
    left_data  = '0;
    right_data = '0;
    for (int k = 0; k < LANES; k++) begin
      left_data  = left_data  | left_term[k];
      right_data = right_data | right_term[k];
    end
  end

  always_comb begin
    strb = '0;
    data = '0;
    case (kind)
      ST_BYTE: begin
        strb = lane_mask;
        data = {LANES{src[LANE_W-1:0]}};
      end
      ST_HALF: begin
        strb = half_strb;
        data = {HALVES{src[2*LANE_W-1:0]}};
      end
      ST_WORD: begin
        strb = '1;
        data = src;
      end
      ST_LEFT: begin
        strb = left_strb;
        data = left_data;
      end
      ST_RIGHT: begin
        strb = right_strb;
        data = right_data;
      end
      default: begin
        strb = '0;
        data = '0;
      end
    endcase
  end
endmodule

// File: rtl/lsu_load_lane.sv
module lsu_load_lane
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int HALVES = LANES / 2,
  localparam int HALF_W = 2 * LANE_W
) (
  input  load_kind_e        kind,
  input  logic [LANES-1:0]  lane_mask,
  input  logic [DATA_W-1:0] mem,
  input  logic [DATA_W-1:0] prev,
  output logic [DATA_W-1:0] result
);
  logic [LANE_W-1:0] byte_term [LANES];
  logic [HALF_W-1:0] half_term [HALVES];
  logic [DATA_W-1:0] left_term  [LANES];
  logic [DATA_W-1:0] right_term [LANES];
  logic [LANE_W-1:0] sel_byte;
  logic [HALF_W-1:0] sel_half;
  logic [DATA_W-1:0] left_val, right_val;

  for (genvar k = 0; k < LANES; k++) begin : g_off
    localparam int LSH = LANE_W * (LANES - 1 - k);
    localparam int RSH = LANE_W * k;
    localparam logic [DATA_W-1:0] KEEP_LO = ~({DATA_W{1'b1}} << LSH);
    localparam logic [DATA_W-1:0] KEEP_HI = ~({DATA_W{1'b1}} >> RSH);
    assign byte_term[k]  = lane_mask[k] ? mem[LANE_W*k +: LANE_W] : '0;
    assign left_term[k]  = lane_mask[k] ? ((mem << LSH) | (prev & KEEP_LO)) : '0;
    assign right_term[k] = lane_mask[k] ? ((mem >> RSH) | (prev & KEEP_HI)) : '0;
  end

  for (genvar p = 0; p < HALVES; p++) begin : g_half
    assign half_term[p] = (lane_mask[2*p] | lane_mask[2*p+1]) ?
                          mem[HALF_W*p +: HALF_W] : '0;
  end

  always_comb begin
    sel_byte  = '0;
    sel_half  = '0;
    left_val  = '0;
    right_val = '0;
    for (int k = 0; k < LANES; k++) begin
      sel_byte  = sel_byte  | byte_term[k];
      left_val  = left_val  | left_term[k];
      right_val = right_val | right_term[k];
    end
    for (int p = 0; p < HALVES; p++) begin
      sel_half = sel_half | half_term[p];
    end
  end

  always_comb begin
    case (kind)
      LD_BYTE_S: result = {{(DATA_W-LANE_W){sel_byte[LANE_W-1]}}, sel_byte};
      LD_BYTE_U: result = {{(DATA_W-LANE_W){1'b0}}, sel_byte};
      LD_HALF_S: result = {{(DATA_W-HALF_W){sel_half[HALF_W-1]}}, sel_half};
      LD_HALF_U: result = {{(DATA_W-HALF_W){1'b0}}, sel_half};
      LD_WORD:   result = mem;
      LD_LEFT:   result = left_val;
      LD_RIGHT:  result = right_val;
      default:   result = '0;
    endcase
  end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        st_op,
  input  logic [2:0]        ld_op,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic [DATA_W-1:0] st_reg,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] old_reg,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  wr_strb,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ld_result
);
  logic [LANES-1:0]  lane_mask;
  logic [LANES-1:0]  strb_c;
  logic [DATA_W-1:0] wdata_c, ldres_c;
  store_kind_e       st_kind;
  load_kind_e        ld_kind;

  assign st_kind = store_kind_e'(st_op);
  assign ld_kind = load_kind_e'(ld_op);

  lsu_lane_decode #(.LANES(LANES)) u_dec (
    .offset    (eff_addr[OFF_W-1:0]),
    .lane_mask (lane_mask)
  );

  lsu_store_lane #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_st (
    .kind      (st_kind),
    .lane_mask (lane_mask),
    .src       (st_reg),
    .strb      (strb_c),
    .data      (wdata_c)
  );

  lsu_load_lane #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_ld (
    .kind      (ld_kind),
    .lane_mask (lane_mask),
    .mem       (mem_rdata),
    .prev      (old_reg),
    .result    (ldres_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      wr_strb   <= '0;
      wr_data   <= '0;
      ld_result <= '0;
    end else begin
      mem_addr  <= {eff_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      wr_strb   <= strb_c;
      wr_data   <= wdata_c;
      ld_result <= ldres_c;
    end
  end
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        st_op,
  input logic [2:0]        ld_op,
  input logic [ADDR_W-1:0] eff_addr,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LANES-1:0]  wr_strb,
  input logic [DATA_W-1:0] ld_result
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= !rst;

  a_r2_word_aligned: assert property (@(posedge clk) disable iff (rst)
    armed |-> (mem_addr == {$past(eff_addr[ADDR_W-1:2]), 2'b00}));

  a_r3_idle_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (armed && ($past(st_op) == 3'd0 || $past(st_op) > 3'd5)) |-> (wr_strb == '0));

  a_r4_byte_single_lane: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(st_op) == 3'd1) |-> ($countones(wr_strb) == 1));

  a_r6_word_all_lanes: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(st_op) == 3'd3) |-> (wr_strb == '1));

  a_r7_left_keeps_lane0: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(st_op) == 3'd4) |-> wr_strb[0]);

  a_r8_right_keeps_top: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(st_op) == 3'd5) |-> wr_strb[LANES-1]);

  a_r11_word_load_passes: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(ld_op) == 3'd5) |-> (ld_result == $past(mem_rdata)));
endmodule

bind lsu_lane_align lsu_lane_align_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
) chk_i (
  .clk(clk), .rst(rst), .st_op(st_op), .ld_op(ld_op), .eff_addr(eff_addr),
  .mem_rdata(mem_rdata), .mem_addr(mem_addr), .wr_strb(wr_strb),
  .ld_result(ld_result)
);

// File: tb/lsu_lane_align_tb_top.sv
`timescale 1ns/1ps
module lsu_lane_align_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  st_op = '0, ld_op = '0;
  logic [31:0] eff_addr = '0, st_reg = '0, mem_rdata = '0, old_reg = '0;
  logic [31:0] mem_addr, wr_data, ld_result;
  logic [3:0]  wr_strb;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lsu_lane_align dut_i (
    .clk(clk), .rst(rst), .st_op(st_op), .ld_op(ld_op), .eff_addr(eff_addr),
    .st_reg(st_reg), .mem_rdata(mem_rdata), .old_reg(old_reg),
    .mem_addr(mem_addr), .wr_strb(wr_strb), .wr_data(wr_data),
    .ld_result(ld_result)
  );

  function automatic logic [3:0] exp_strb(input logic [2:0] op, input int k);
    case (op)
      3'd1: return 4'b0001 << k;
      3'd2: return (k >= 2) ? 4'b1100 : 4'b0011;
      3'd3: return 4'b1111;
      3'd4: case (k) 0: return 4'b0001; 1: return 4'b0011;
                     2: return 4'b0111; default: return 4'b1111; endcase
      3'd5: case (k) 0: return 4'b1111; 1: return 4'b1110;
                     2: return 4'b1100; default: return 4'b1000; endcase
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] exp_wdata(input logic [2:0] op, input int k,
                                            input logic [31:0] r);
    case (op)
      3'd1: return {r[7:0], r[7:0], r[7:0], r[7:0]};
      3'd2: return {r[15:0], r[15:0]};
      3'd3: return r;
      3'd4: return r >> (8 * (3 - k));
      3'd5: return r << (8 * k);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_load(input logic [2:0] op, input int k,
                                           input logic [31:0] m, input logic [31:0] r);
    logic [7:0]  b;
    logic [15:0] h;
    b = m[8*k +: 8];
    h = (k >= 2) ? m[31:16] : m[15:0];
    case (op)
      3'd1: return {{24{b[7]}}, b};
      3'd2: return {24'h0, b};
      3'd3: return {{16{h[15]}}, h};
      3'd4: return {16'h0, h};
      3'd5: return m;
      3'd6: case (k) 3: return m; 2: return {m[23:0], r[7:0]};
                     1: return {m[15:0], r[15:0]}; default: return {m[7:0], r[23:0]}; endcase
      3'd7: case (k) 0: return m; 1: return {r[31:24], m[31:8]};
                     2: return {r[31:16], m[31:16]}; default: return {r[31:8], m[31:24]}; endcase
      default: return 32'h0;
    endcase
  endfunction

  function automatic string st_tag(input logic [2:0] op);
    case (op)
      3'd1: return "R4"; 3'd2: return "R5"; 3'd3: return "R6";
      3'd4: return "R7"; 3'd5: return "R8"; default: return "R3";
    endcase
  endfunction

  function automatic string ld_tag(input logic [2:0] op);
    case (op)
      3'd1, 3'd2: return "R9"; 3'd3, 3'd4: return "R10";
      3'd6: return "R12"; 3'd7: return "R13"; default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] so, input logic [2:0] lo, input logic [31:0] a,
                       input logic [31:0] sr, input logic [31:0] m, input logic [31:0] r);
    int k;
    @(negedge clk);
    st_op = so; ld_op = lo; eff_addr = a; st_reg = sr; mem_rdata = m; old_reg = r;
    k = int'(a[1:0]);
    @(posedge clk);
    #1;
    chk("R2", "mem_addr", mem_addr, {a[31:2], 2'b00});
    chk(st_tag(so), "wr_strb", {28'h0, wr_strb}, {28'h0, exp_strb(so, k)});
    chk(st_tag(so), "wr_data", wr_data, exp_wdata(so, k, sr));
    chk(ld_tag(lo), "ld_result", ld_result, exp_load(lo, k, m, r));
  endtask

  initial begin
    logic [31:0] a;
    logic [2:0]  so, lo;
    void'($urandom(32'd20240530));
    // R1: outputs stay zero under reset even with busy inputs
    st_op = 3'd3; ld_op = 3'd5; eff_addr = 32'hFFFF_FFFF;
    st_reg = 32'hDEAD_BEEF; mem_rdata = 32'hCAFE_F00D; old_reg = 32'h1234_5678;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "mem_addr reset", mem_addr, 32'h0);
    chk("R1", "wr_strb reset", {28'h0, wr_strb}, 32'h0);
    chk("R1", "wr_data reset", wr_data, 32'h0);
    chk("R1", "ld_result reset", ld_result, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    // R1 latency: first registered value after release
    @(posedge clk);
    #1;
    chk("R1", "first word load", ld_result, 32'hCAFE_F00D);
    // directed sweep: every kind at every offset
    for (int k = 0; k < 4; k++) begin
      for (int op = 0; op < 8; op++) begin
        so = 3'(op);
        lo = 3'(op);
        a = 32'h8000_1230 | 32'(k);
        if ((op == 2 || op == 3 || op == 4) && k[0]) a[0] = 1'b0;
        apply(so, lo, a, 32'h8A7B_6C9D, 32'hF1E2_D3C4, 32'h0F1E_2D3C);
      end
    end
    // sign boundaries for R9 and R10
    apply(3'd0, 3'd1, 32'h3, 32'h0, 32'h7F00_0000, 32'h0);
    apply(3'd0, 3'd1, 32'h1, 32'h0, 32'h0000_8000, 32'h0);
    apply(3'd0, 3'd3, 32'h2, 32'h0, 32'h8000_0000, 32'h0);
    apply(3'd0, 3'd4, 32'h0, 32'h0, 32'h0000_FFFF, 32'h0);
    // random mix
    for (int i = 0; i < 600; i++) begin
      so = 3'($urandom_range(0, 7));
      lo = 3'($urandom_range(0, 7));
      a = $urandom();
      if (so == 3'd2 || lo == 3'd3 || lo == 3'd4) a[0] = 1'b0;
      apply(so, lo, a, $urandom(), $urandom(), $urandom());
    end
    // R1: reset re-asserted mid-run clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", "wr_strb rereset", {28'h0, wr_strb}, 32'h0);
    chk("R1", "ld_result rereset", ld_result, 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule